// File: doc/BRIEF.md
# Segmented Survivor-Memory Trace-Back

This block is the survivor store and trace-back engine of a state-serial Viterbi decoder. For every received symbol the add-compare-select stage delivers one decision bit per trellis state. It delivers them as several narrow segments, each tagged with its segment index. The block writes each segment into one narrow dual-port RAM that works as a circular buffer. The segments of one symbol occupy adjacent words, with the segment index as the low address bits. A strobe marks the end of a symbol and carries the best state found for it.

Each time a block of decoded bits falls due, the block walks the trellis backwards from the supplied best state. Each step reads only the one segment that holds the decision of the current state. The previous state is the current state shifted right, with that decision inserted as the new most significant bit. The least significant bit of every visited state is the information bit that led into it. The early steps of the walk only let the path converge. The final steps collect the decoded bits newest first. A shift register restores time order before the bits are presented as one parallel word with a one-cycle valid pulse.

The newest few buffer slots are not visited by a walk. They take the symbols that arrive while a walk is running, so writing never has to pause.

Top module: `tbu_segmented`

## Requirements
- R1: While reset is asserted, and afterwards until the first block is delivered, out_valid is 0 and out_bits is all zeros.
- R2: No block is delivered until 2^DEPTH_LOG - 2^NDEC_LOG symbols (56 by default) have been completed since reset. The first walk starts on that completing strobe, and the same priming applies again after every reset.
- R3: After priming, every 2^NDEC_LOG-th sym_done strobe (every 8th by default) starts one walk. Each walk gives exactly one out_valid pulse, one cycle long.
- R4: The k-th block after reset carries, in out_bits[i], the information bit of symbol 8k+i, counted from the first symbol after reset, so the oldest bit is in bit 0. Walk rule: previous state = {decision, state >> 1}, and the decoded bit is the state's LSB.
- R5: The decision of state s is bit s[3:0] of segment s[5:4]. The segments of one symbol may arrive in any order, one per dec_valid cycle, with dec_idx naming the segment.
- R6: out_valid rises exactly 2*(2^DEPTH_LOG - 2^NDEC_LOG) cycles (112 by default) after the clock edge that samples the walk-starting sym_done.
- R7: While dec_valid is 0, dec_idx and dec_seg have no effect on the stored decisions.
- R8: best_state is used only on the walk-starting sym_done. Its value in other cycles has no effect.
- R9: out_bits holds its value between out_valid pulses.
- R10: Up to 2^NDEC_LOG symbols written while a walk runs do not disturb that walk's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | A decision segment is present this cycle |
| dec_idx | input | SEG_LOG | Segment index of dec_seg (high state bits) |
| dec_seg | input | 2^ST_W / 2^SEG_LOG | Decision bits of one segment, indexed by low state bits |
| sym_done | input | 1 | All segments of the current symbol are stored |
| best_state | input | ST_W | Best state of the symbol closed by sym_done |
| out_valid | output | 1 | One-cycle pulse: out_bits carries a new block |
| out_bits | output | 2^NDEC_LOG | Decoded bits, oldest in bit 0 |

## Verification
The bench builds the block with its defaults: 64 states in four 16-bit segments, a 64-symbol buffer and 8-bit blocks. This makes a walk 56 steps deep and gives 112 cycles of latency, so priming, cadence and latency are all reached within a few thousand cycles. Decisions come from a reference encoder path, with pseudo-random bits for every off-path state. Any mistake in segment addressing, bit selection or the walk rule therefore sends the walk off the true path and corrupts the decoded bits. Segment order, ignored write cycles and a second reset are varied so that reuse of the reserved slots and re-priming are both exercised.

// File: rtl/tbu_pkg.sv
package tbu_pkg;
  // Two-cycle step of the backward walk: present address, then consume word.
  typedef enum logic {
    PH_ISSUE = 1'b0,
    PH_USE   = 1'b1
  } tb_phase_e;
endpackage

// File: rtl/tbu_dec_ram.sv
module tbu_dec_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic              re,
  input  logic [ADDR_W-1:0] ra,
  output logic [DATA_W-1:0] rq
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (re) rq <= mem[ra];
  end
endmodule

// File: rtl/tbu_wr_ctrl.sv
module tbu_wr_ctrl #(
  parameter int SEG_LOG   = 2,
  parameter int DEPTH_LOG = 6,
  parameter int NDEC_LOG  = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        dec_valid,
  input  logic [SEG_LOG-1:0]          dec_idx,
  input  logic                        sym_done,
  output logic                        wr_en,
  output logic [DEPTH_LOG+SEG_LOG-1:0] wr_addr,
  output logic [DEPTH_LOG-1:0]        head_ptr,
  output logic                        tb_start,
  output logic                        primed
);
  localparam int NDEC  = 1 << NDEC_LOG;
  localparam int LBLK  = (1 << (DEPTH_LOG - NDEC_LOG)) - 1;
  localparam int BLK_W = $clog2(LBLK + 1);

  logic [DEPTH_LOG-1:0] wptr;
  logic [NDEC_LOG-1:0]  sub_cnt;
  logic [BLK_W-1:0]     blk_cnt;
  logic                 block_end;

  assign wr_en     = dec_valid;
  assign wr_addr   = {wptr, dec_idx};
  assign head_ptr  = wptr;
  assign block_end = sym_done && (sub_cnt == NDEC_LOG'(NDEC - 1));
  assign tb_start  = block_end && (blk_cnt >= BLK_W'(LBLK - 1));
  assign primed    = (blk_cnt == BLK_W'(LBLK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      sub_cnt <= '0;
      blk_cnt <= '0;
    end else if (sym_done) begin
      wptr    <= wptr + 1'b1;
      sub_cnt <= sub_cnt + 1'b1;
      if (block_end && !primed) blk_cnt <= blk_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tbu_walker.sv
module tbu_walker
  import tbu_pkg::*;
#(
  parameter int ST_W      = 6,
  parameter int SEG_LOG   = 2,
  parameter int DEPTH_LOG = 6,
  parameter int NDEC_LOG  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [ST_W-1:0]              start_state,
  input  logic [DEPTH_LOG-1:0]         start_ptr,
  input  logic [(1<<ST_W)/(1<<SEG_LOG)-1:0] rd_q,
  output logic                         rd_en,
  output logic [DEPTH_LOG+SEG_LOG-1:0] rd_addr,
  output logic                         busy,
  output logic                         out_valid,
  output logic [(1<<NDEC_LOG)-1:0]     out_bits
);
  localparam int SEG_W     = (1 << ST_W) >> SEG_LOG;
  localparam int LOW_W     = ST_W - SEG_LOG;
  localparam int NDEC      = 1 << NDEC_LOG;
  localparam int TRACE_LEN = (1 << DEPTH_LOG) - NDEC;
  localparam int OUT_FROM  = TRACE_LEN - NDEC;
  localparam int STEP_W    = $clog2(TRACE_LEN);

  function automatic logic [ST_W-1:0] back_step(input logic [ST_W-1:0] s, input logic d);
    return {d, s[ST_W-1:1]};
  endfunction

  function automatic logic pick_bit(input logic [SEG_W-1:0] w, input logic [ST_W-1:0] s);
    return w[s[LOW_W-1:0]];
  endfunction

  tb_phase_e             phase;
  logic [ST_W-1:0]       cur;
  logic [DEPTH_LOG-1:0]  rptr;
  logic [STEP_W-1:0]     step;
  logic [NDEC-1:0]       shreg;
  logic [NDEC-1:0]       shift_nxt;
  logic                  step_take;
  logic                  keep;
  logic                  last;
  logic                  dec_bit;

  assign rd_en     = busy && (phase == PH_ISSUE);
  assign rd_addr   = {rptr, cur[ST_W-1 -: SEG_LOG]};
  assign step_take = busy && (phase == PH_USE);
  assign dec_bit   = pick_bit(rd_q, cur);
  assign keep      = (step >= STEP_W'(OUT_FROM));
  assign last      = (step == STEP_W'(TRACE_LEN - 1));
  assign shift_nxt = {shreg[NDEC-2:0], cur[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      phase     <= PH_ISSUE;
      cur       <= '0;
      rptr      <= '0;
      step      <= '0;
      shreg     <= '0;
      out_bits  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          phase <= PH_ISSUE;
          cur   <= start_state;
          rptr  <= start_ptr;
          step  <= '0;
        end
      end else if (phase == PH_ISSUE) begin
        phase <= PH_USE;
      end else begin
        if (keep) shreg <= shift_nxt;
        cur   <= back_step(cur, dec_bit);
        rptr  <= rptr - 1'b1;
        step  <= step + 1'b1;
        phase <= PH_ISSUE;
        if (last) begin
          busy      <= 1'b0;
          out_bits  <= shift_nxt;
          out_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tbu_segmented.sv
module tbu_segmented #(
  parameter int ST_W      = 6,
  parameter int SEG_LOG   = 2,
  parameter int DEPTH_LOG = 6,
  parameter int NDEC_LOG  = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                dec_valid,
  input  logic [SEG_LOG-1:0]                  dec_idx,
  input  logic [(1<<ST_W)/(1<<SEG_LOG)-1:0]   dec_seg,
  input  logic                                sym_done,
  input  logic [ST_W-1:0]                     best_state,
  output logic                                out_valid,
  output logic [(1<<NDEC_LOG)-1:0]            out_bits
);
  localparam int SEG_W  = (1 << ST_W) >> SEG_LOG;
  localparam int ADDR_W = DEPTH_LOG + SEG_LOG;

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [SEG_W-1:0]  rd_q;
  logic [DEPTH_LOG-1:0] head_ptr;
  logic              tb_start;
  logic              primed;
  logic              busy;

  tbu_wr_ctrl #(
    .SEG_LOG(SEG_LOG), .DEPTH_LOG(DEPTH_LOG), .NDEC_LOG(NDEC_LOG)
  ) u_wr (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_idx(dec_idx),
    .sym_done(sym_done), .wr_en(wr_en), .wr_addr(wr_addr),
    .head_ptr(head_ptr), .tb_start(tb_start), .primed(primed)
  );

  tbu_dec_ram #(.ADDR_W(ADDR_W), .DATA_W(SEG_W)) u_ram (
    .clk(clk), .we(wr_en), .wa(wr_addr), .wd(dec_seg),
    .re(rd_en), .ra(rd_addr), .rq(rd_q)
  );

  tbu_walker #(
    .ST_W(ST_W), .SEG_LOG(SEG_LOG), .DEPTH_LOG(DEPTH_LOG), .NDEC_LOG(NDEC_LOG)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .start(tb_start), .start_state(best_state),
    .start_ptr(head_ptr), .rd_q(rd_q), .rd_en(rd_en), .rd_addr(rd_addr),
    .busy(busy), .out_valid(out_valid), .out_bits(out_bits)
  );
endmodule

// File: rtl/tbu_segmented_chk.sv
module tbu_segmented_chk #(
  parameter int DEPTH_LOG = 6,
  parameter int NDEC_LOG  = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        tb_start,
  input logic                        busy,
  input logic                        primed,
  input logic                        out_valid,
  input logic [(1<<NDEC_LOG)-1:0]    out_bits
);
  localparam int LAT   = 2 * ((1 << DEPTH_LOG) - (1 << NDEC_LOG));
  localparam int CNT_W = $clog2(LAT + 2);

  logic [CNT_W-1:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) lat_cnt <= '1;
    else if (tb_start) lat_cnt <= '0;
    else if (lat_cnt != '1) lat_cnt <= lat_cnt + 1'b1;
  end

  // R2: nothing leaves the block before the buffer is primed
  a_r2_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !out_valid);

  // R3: each block is a one-cycle pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R3: a new walk never starts while one runs
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    tb_start |-> !busy);

  // R6: fixed distance from walk start to delivered block
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (lat_cnt == CNT_W'(LAT)));

  // R9: output word changes only together with a pulse
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_bits) |-> out_valid);
endmodule

bind tbu_segmented tbu_segmented_chk #(
  .DEPTH_LOG(DEPTH_LOG), .NDEC_LOG(NDEC_LOG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tb_start(tb_start), .busy(busy),
  .primed(primed), .out_valid(out_valid), .out_bits(out_bits)
);

// File: tb/tbu_segmented_bench.sv
module tbu_segmented_bench;
  localparam int LAT  = 112;
  localparam int PRIME = 56;

  // {ignored-write flag, four 2-bit segment indices, first in low bits}
  localparam logic [8:0] PAT [8] = '{
    9'h0E4, 9'h11B, 9'h072, 9'h18D, 9'h1E4, 9'h01B, 9'h172, 9'h08D
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 1'b0;
  logic [1:0] dec_idx = '0;
  logic [15:0] dec_seg = '0;
  logic sym_done = 1'b0;
  logic [5:0] best_state = '0;
  logic out_valid;
  logic [7:0] out_bits;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int seed = 1;
  int blk = 0;
  int nstart = 0;
  int start_cyc [32];
  bit u_arr [256];
  logic [5:0] enc = '0;
  logic [7:0] held = '0;
  logic prev_ov = 1'b0;
  bit done = 1'b0;

  tbu_segmented u_tbu_segmented (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_idx(dec_idx),
    .dec_seg(dec_seg), .sym_done(sym_done), .best_state(best_state),
    .out_valid(out_valid), .out_bits(out_bits)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int mix(input int a);
    int x;
    x = a * 32'h9E3779B1;
    x = x ^ (x >> 15);
    x = x * 32'h85EBCA77;
    x = x ^ (x >> 13);
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // One symbol: segments in table order, optional ignored write, then strobe.
  task automatic send_sym(input int n, input logic [8:0] pat);
    logic [63:0] dv;
    logic [5:0] nxt;
    logic [1:0] ix;
    int r;
    r = mix(seed * 7919 + n);
    nxt = {enc[4:0], r[0]};
    for (int s = 0; s < 64; s++) begin
      r = mix(seed * 104729 + n * 64 + s + 17);
      dv[s] = (6'(s) == nxt) ? enc[5] : r[3];
    end
    u_arr[n] = nxt[0];
    enc = nxt;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ix = pat[2*k +: 2];
      dec_valid = 1'b1; dec_idx = ix; dec_seg = dv[ix*16 +: 16];
    end
    @(negedge clk);
    dec_valid = 1'b0;
    if (pat[8]) begin // R7: a corrupting word on the path segment, not enabled
      dec_idx = nxt[5:4];
      dec_seg = ~dv[nxt[5:4]*16 +: 16];
    end
    @(negedge clk);
    sym_done = 1'b1; best_state = nxt;
    if (((n + 1) % 8 == 0) && (n + 1 >= PRIME)) begin
      start_cyc[nstart] = cyc + 1;
      nstart++;
    end
    @(negedge clk);
    sym_done = 1'b0; best_state = ~nxt; // R8: garbage between strobes
    repeat (10) @(negedge clk);
  endtask

  // Output monitor: R2, R3, R4, R6, R9, R10
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (blk >= nstart) begin
          check(1'b0, "R2 pulse without a due walk", blk, nstart);
        end else begin
          check(cyc - start_cyc[blk] == LAT, "R6 latency", cyc - start_cyc[blk], LAT);
          for (int i = 0; i < 8; i++)
            check(out_bits[i] == u_arr[8*blk + i], "R4/R5/R10 decoded bit",
                  {24'd0, out_bits}, 8*blk + i);
          blk++;
        end
        check(!prev_ov, "R3 single-cycle pulse", prev_ov, 0);
        held = out_bits;
      end else if (out_bits != held) begin
        check(1'b0, "R9 hold between pulses", out_bits, held);
      end
      prev_ov = out_valid;
    end else begin
      prev_ov = 1'b0;
      held = '0;
    end
  end

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    check(out_bits == 8'd0, "R1 bits in reset", out_bits, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_bits == 8'd0, "R1 after reset", out_bits, 0);

    // Phase 1: walk the pattern table over 152 symbols (13 blocks)
    for (int n = 0; n < 152; n++) begin
      send_sym(n, PAT[n % 8]);
      if (n == PRIME - 2) check(blk == 0, "R2 still priming", blk, 0);
    end
    repeat (130) @(negedge clk);
    check(blk == 13, "R3 block count phase 1", blk, 13);

    // Phase 2: reset mid-stream, new data, priming must restart
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_bits == 8'd0, "R1 second reset", out_bits, 0);
    blk = 0; nstart = 0; enc = '0; seed = 5;
    rst_n = 1'b1;
    for (int n = 0; n < 64; n++) begin
      send_sym(n, PAT[(n * 3) % 8]);
      if (n == PRIME - 2) check(blk == 0, "R2 re-priming", blk, 0);
    end
    repeat (130) @(negedge clk);
    check(blk == 2, "R3 block count phase 2", blk, 2);
    finish_run();
  end
endmodule